// File: doc/BRIEF.md
# Legacy Region Attribute Decoder

This block sits on the memory path of a chipset and decides, for each access that falls between 768 KB and 1 MB, whether it is served by DRAM or passed on to the memory-mapped I/O path. The window is cut into thirteen sub-regions: twelve 16 KB slices from 0xC0000 to 0xEFFFF and a single 64 KB slice from 0xF0000 to 0xFFFFF. Each sub-region has its own 2-bit attribute. The attribute can send reads and writes to different targets, so a region can be made read-only or write-only as seen from DRAM.

Seven attribute bytes are loaded through a simple write port with a byte index, and they can be read back on the same index. Each cycle an access arrives as an address, a read/write flag and a valid strobe. One clock later the block presents a registered decision: DRAM or I/O, plus a flag that marks addresses outside the window. Those addresses are always routed to DRAM.

Top module: `legacy_window_router`

## Requirements
- R1: After reset all attribute bytes read back 0x00, and every access inside the window is routed to I/O (route_dram low) for both reads and writes.
- R2: An attribute of 00 routes reads and writes to I/O. An attribute of 01 routes reads to DRAM and writes to I/O. An attribute of 10 routes writes to DRAM and reads to I/O. An attribute of 11 routes both to DRAM.
- R3: Addresses 0xF0000 to 0xFFFFF form a single region whose attribute is bits [5:4] of byte index 0.
- R4: Region n (0..11) covers 0xC0000 + n*0x4000 up to 0x3FFF above that base. Its attribute sits in byte index 1 + n/2, in bits [1:0] for even n and in bits [5:4] for odd n.
- R5: An address below 0xC0000 or at or above 0x100000 gives route_dram = 1 and route_outside = 1. Any address inside the window gives route_outside = 0.
- R6: route_valid equals acc_valid delayed by one clock. While route_valid is low, route_dram and route_outside are 0. The decision uses the attribute bytes as they stood before the clock edge at which the access was sampled, so a write in the same cycle affects only later accesses.
- R7: Bits [7:6] and [3:2] of every byte, and bits [1:0] of byte index 0, ignore writes and read as zero. Writes to index 7 are ignored, and index 7 reads as 0x00.
- R8: cfg_rdata shows, without a clock delay, the stored byte selected by cfg_idx. A write becomes visible from the next cycle.
- R9: Writing 0x30 to index 0 and 0x33 to indexes 1..6 routes every read and write in the window to DRAM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Attribute byte write enable |
| cfg_idx | input | 3 | Byte index for write and readback (0..6 valid) |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Readback of the byte selected by cfg_idx |
| acc_valid | input | 1 | Access strobe |
| acc_addr | input | ADDR_W | Access byte address |
| acc_write | input | 1 | 1 = write access, 0 = read access |
| route_valid | output | 1 | Decision valid, one cycle after acc_valid |
| route_dram | output | 1 | 1 = serve from DRAM, 0 = forward to I/O |
| route_outside | output | 1 | Address lies outside the legacy window |

## Verification
Route outputs are due exactly one clock after the access is sampled. Readback is due in the same cycle as its index, and it reflects a write from the following cycle onward. The bench keeps a behavioural model that is updated at each rising edge, with the old attribute values used for the access and the write applied afterwards. At the next falling edge it compares all three route outputs and cfg_rdata against that model. An access issued in the same cycle as a configuration write therefore expects the old attribute, and the cycle after it expects the new one.

// File: rtl/legacy_window_router.sv
module legacy_window_router #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_idx,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_write,
  output logic              route_valid,
  output logic              route_dram,
  output logic              route_outside
);
  localparam int NBYTES = 7;
  localparam logic [ADDR_W-1:0] WIN_LO = ADDR_W'(32'h000C_0000);
  localparam logic [ADDR_W-1:0] TOP_LO = ADDR_W'(32'h000F_0000);
  localparam logic [ADDR_W-1:0] WIN_HI = ADDR_W'(32'h0010_0000);

  logic [7:0] attr_q [NBYTES];
  logic       in_win, top_hit;
  logic [3:0] seg;
  logic [2:0] sel;
  logic [1:0] attr;

  assign in_win  = (acc_addr >= WIN_LO) && (acc_addr < WIN_HI);
  assign top_hit = acc_addr >= TOP_LO;
  assign seg     = acc_addr[17:14];
  assign sel     = top_hit ? 3'd0 : 3'(seg[3:1]) + 3'd1;

  genvar g;
  generate
    for (g = 0; g < NBYTES; g++) begin : g_byte
      localparam logic [7:0] KEEP = (g == 0) ? 8'h30 : 8'h33;
      always_ff @(posedge clk) begin
        if (!rst_n)
          attr_q[g] <= 8'h00;
        else if (cfg_we && cfg_idx == 3'(g))
          attr_q[g] <= cfg_wdata & KEEP;
      end
    end
  endgenerate

  always_comb begin
    cfg_rdata = 8'h00;
    attr      = 2'b00;
    for (int i = 0; i < NBYTES; i++) begin
      if (cfg_idx == 3'(i)) cfg_rdata = attr_q[i];
      if (sel == 3'(i))
        attr = (top_hit || seg[0]) ? attr_q[i][5:4] : attr_q[i][1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      route_valid   <= 1'b0;
      route_dram    <= 1'b0;
      route_outside <= 1'b0;
    end else begin
      route_valid   <= acc_valid;
      route_dram    <= acc_valid && (!in_win || (acc_write ? attr[1] : attr[0]));
      route_outside <= acc_valid && !in_win;
    end
  end
endmodule

module legacy_window_router_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [7:0]        cfg_rdata,
  input logic              acc_valid,
  input logic [ADDR_W-1:0] acc_addr,
  input logic              route_valid,
  input logic              route_dram,
  input logic              route_outside
);
  logic outside_addr;
  assign outside_addr = (acc_addr < ADDR_W'(32'h000C_0000)) || (acc_addr >= ADDR_W'(32'h0010_0000));

  // R6
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> route_valid);
  // R6
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> !route_valid);
  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !route_valid |-> (!route_dram && !route_outside));
  // R5
  outside_dram_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && outside_addr) |=> (route_outside && route_dram));
  // R5
  inside_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !outside_addr) |=> !route_outside);
  // R7
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[7:6] == 2'b00) && (cfg_rdata[3:2] == 2'b00));
endmodule

bind legacy_window_router legacy_window_router_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_rdata(cfg_rdata), .acc_valid(acc_valid),
  .acc_addr(acc_addr), .route_valid(route_valid), .route_dram(route_dram),
  .route_outside(route_outside)
);

// File: tb/legacy_window_router_test.sv
module legacy_window_router_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_idx = 3'd0;
  logic [7:0]  cfg_wdata = 8'h00;
  logic [7:0]  cfg_rdata;
  logic        acc_valid = 1'b0;
  logic [31:0] acc_addr = 32'h0;
  logic        acc_write = 1'b0;
  logic        route_valid, route_dram, route_outside;

  int checks = 0;
  int failures = 0;
  string cur_req = "R1";
  string exp_tag = "R1";
  string rd_req = "R1";

  int m_cfg [8];
  bit e_valid, e_dram, e_out;

  legacy_window_router uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .acc_valid(acc_valid),
    .acc_addr(acc_addr), .acc_write(acc_write), .route_valid(route_valid),
    .route_dram(route_dram), .route_outside(route_outside)
  );

  always #2 clk = ~clk;

  function automatic int region_attr(longint a);
    int n;
    if (a >= 64'hF0000) return (m_cfg[0] / 16) % 4;
    n = int'((a - 64'hC0000) / 64'h4000);
    if (n % 2 == 1) return (m_cfg[1 + n / 2] / 16) % 4;
    return m_cfg[1 + n / 2] % 4;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) m_cfg[i] = 0;
      e_valid = 0; e_dram = 0; e_out = 0;
    end else begin
      int at;
      e_valid = acc_valid;
      e_dram = 0; e_out = 0;
      exp_tag = cur_req;
      if (acc_valid) begin
        if (acc_addr < 32'hC0000 || acc_addr >= 32'h100000) begin
          e_dram = 1; e_out = 1;
        end else begin
          at = region_attr(longint'(acc_addr));
          e_dram = acc_write ? (at >= 2) : (at % 2 == 1);
        end
      end
      if (cfg_we && cfg_idx < 3'd7)
        m_cfg[cfg_idx] = int'(cfg_wdata) & ((cfg_idx == 3'd0) ? 'h30 : 'h33);
    end
  end

  task automatic check_now();
    int er;
    checks++;
    if ({route_valid, route_dram, route_outside} !== {e_valid, e_dram, e_out}) begin
      failures++;
      $display("FAIL %s route v/d/o actual=%b%b%b expected=%b%b%b", exp_tag,
               route_valid, route_dram, route_outside, e_valid, e_dram, e_out);
    end
    er = m_cfg[cfg_idx];
    checks++;
    if (int'(cfg_rdata) != er) begin
      failures++;
      $display("FAIL %s readback idx=%0d actual=%h expected=%h", rd_req, cfg_idx, cfg_rdata, er);
    end
  endtask

  task automatic step();
    @(negedge clk);
    check_now();
    cfg_we = 1'b0;
    acc_valid = 1'b0;
  endtask

  task automatic wr_cfg(int idx, int val, string tag);
    step();
    rd_req = tag;
    cfg_we = 1'b1; cfg_idx = 3'(idx); cfg_wdata = 8'(val);
  endtask

  task automatic rd_cfg(int idx, string tag);
    step();
    rd_req = tag;
    cfg_idx = 3'(idx);
  endtask

  task automatic access(longint a, bit w, string tag);
    step();
    cur_req = tag;
    acc_valid = 1'b1; acc_addr = 32'(a); acc_write = w;
  endtask

  task automatic sweep(string tag_low, string tag_top);
    for (int n = 0; n < 13; n++) begin
      longint base = (n < 12) ? 64'hC0000 + n * 64'h4000 : 64'hF0000;
      longint last = base + ((n < 12) ? 64'h3FFF : 64'hFFFF);
      string t = (n < 12) ? tag_low : tag_top;
      access(base, 1'b0, t);
      access(base, 1'b1, t);
      access(last, 1'b0, t);
      access(last, 1'b1, t);
    end
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    // R1: reset contents and I/O routing
    for (int i = 0; i < 8; i++) rd_cfg(i, "R1");
    sweep("R1", "R1");
    // R2, R3, R4: varied attribute patterns with junk in reserved bits
    for (int p = 0; p < 4; p++) begin
      wr_cfg(0, 'hCF | (((p) % 4) << 4), "R3");
      for (int b = 1; b < 7; b++)
        wr_cfg(b, 'hCC | ((p + 2 * b) % 4) | (((p + 2 * b + 1) % 4) << 4), "R4");
      sweep(p == 0 ? "R4" : "R2", "R3");
    end
    // R5: outside the window
    access(64'h0, 1'b0, "R5");
    access(64'hBFFFF, 1'b1, "R5");
    access(64'h100000, 1'b0, "R5");
    access(64'hFFFFFFFF, 1'b1, "R5");
    access(64'hA0000, 1'b0, "R5");
    // R7, R8: reserved bits and index 7
    for (int i = 0; i < 8; i++) wr_cfg(i, 'hFF, "R7");
    for (int i = 0; i < 8; i++) rd_cfg(i, "R8");
    wr_cfg(7, 'h5A, "R7");
    rd_cfg(7, "R7");
    // R9: full enable
    wr_cfg(0, 'h30, "R9");
    for (int b = 1; b < 7; b++) wr_cfg(b, 'h33, "R9");
    sweep("R9", "R9");
    // R6: write and access in the same cycle, then back-to-back accesses
    wr_cfg(2, 'h00, "R6");
    acc_valid = 1'b1; acc_addr = 32'hC8000; acc_write = 1'b0; cur_req = "R6";
    access(64'hC8000, 1'b0, "R6");
    access(64'hCC000, 1'b1, "R6");
    step();
    access(64'hC4000, 1'b1, "R6");
    repeat (3) step();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule